// File: doc/BRIEF.md
# Neighbor Mailbox Communication Unit

This unit connects a compute engine to its immediate neighbors through two independent local ports. In any cycle each port may read one word from a chosen neighbor, write one word to a chosen neighbor, or do both. Every link is a single-word mailbox. An outgoing link is a register inside this unit that holds one word and a full flag. An incoming link is the neighbor's own mailbox, which is seen through a valid/ready pair.

A port asks for a transfer with its request lines. If a transfer cannot finish, the unit raises one shared stall line toward the engine. This happens when a read finds the addressed incoming link empty, or when a write finds the addressed outgoing link still full. While stall is high the engine holds all of its request lines steady.

A transfer that finishes while another port is still blocked is remembered, so it is never repeated. If that transfer was a read, its word is held on the port's read data until stall falls. The engine takes read data in the first cycle that stall is low.

Both neighbor directions follow valid/ready rules. On an outgoing link, `tx_valid` comes from a register and never depends on `tx_ready`. A word moves on a clock edge where both are high, and while valid is high and ready is low the word and valid stay unchanged. On an incoming link, `rx_ready` is raised only in a cycle where `rx_valid` is high and a port is taking that word. `rx_ready` may depend on `rx_valid` in the same cycle.

Top module: `nbcomm_unit`

## Requirements
- R1: While reset is held and after it is released, every `tx_valid` bit is 0. `stall` is 0 in any cycle where no port requests anything.
- R2: A write to an outgoing link that is empty completes with `stall` low. After the next clock edge that link shows `tx_valid` high and carries the written word.
- R3: A write to an outgoing link whose word has not yet been taken raises `stall`. The write stays pending and completes in the first cycle the link is empty again, and the old word is sent before the new one.
- R4: A read from an incoming link with `rx_valid` high completes in the same cycle. `stall` stays low, `rx_ready` is high for that link, and the port's read data equals that link's `rx_data`.
- R5: A read from an incoming link with `rx_valid` low raises `stall` and leaves `rx_ready` low. The read completes in the first cycle `rx_valid` is high.
- R6: When both ports write the same outgoing link in one cycle, port 0 is served and port 1 stalls until the link has been emptied.
- R7: When both ports read the same incoming link in one cycle, port 0 takes the word and port 1 stalls until a further word is valid.
- R8: Two ports addressing different links complete in the same cycle without a stall.
- R9: A port that completes while the other port keeps `stall` high performs its transfer only once. For a read, the port keeps the received word on its read data until `stall` falls.
- R10: An outgoing link with `tx_valid` high and `tx_ready` low keeps `tx_valid` high and `tx_data` unchanged on the next cycle.
- R11: Select value n (2 bits in the default configuration) addresses link n. Port p's select is `port_sel[2p+1:2p]`, and link n uses bit n of the link vectors and bits `[16n+15:16n]` of the link data buses.
- R12: `rx_ready` is never high for a link unless `rx_valid` is high and a port is reading that link in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_sel | input | NUM_PORTS*SEL_W | Neighbor select per port |
| port_rd_req | input | NUM_PORTS | Read request per port |
| port_wr_req | input | NUM_PORTS | Write request per port |
| port_wr_data | input | NUM_PORTS*DATA_W | Word to write, per port |
| port_rd_data | output | NUM_PORTS*DATA_W | Received word, per port |
| stall | output | 1 | Some requested transfer could not complete |
| tx_valid | output | NUM_NBR | Outgoing link holds a word |
| tx_ready | input | NUM_NBR | Neighbor takes the outgoing word |
| tx_data | output | NUM_NBR*DATA_W | Outgoing words |
| rx_valid | input | NUM_NBR | Neighbor mailbox toward this unit is full |
| rx_ready | output | NUM_NBR | This unit takes the incoming word |
| rx_data | input | NUM_NBR*DATA_W | Incoming words |

## Verification
The hardest case to reach is a split outcome: one port finishes while the other keeps the engine stalled, so the finished transfer must be neither lost nor repeated. The stimulus gets there in two ways. In one, port 0 reads a valid link while port 1 reads an empty one, and then the bench withdraws the consumed word, so the held read data is the only copy left. In the other, both ports write the same empty link, and the bench drains it one word at a time to show that the words arrive in port order with no duplicate.

// File: rtl/nbcomm_pkg.sv
package nbcomm_pkg;
  localparam int unsigned PORTS_DEF  = 2;
  localparam int unsigned NBRS_DEF   = 4;
  localparam int unsigned WORD_W_DEF = 16;

  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/nbcomm_mailbox.sv
module nbcomm_mailbox #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else begin
      if (wr_en) begin
        full <= 1'b1;
        word <= wr_word;
      end else if (full && take) begin
        full <= 1'b0;
      end
    end
  end

  // R10: an unaccepted word stays put
  a_r10_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(word)));
  // R3: a full mailbox is never overwritten
  a_r3_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
endmodule

// File: rtl/nbcomm_route.sv
module nbcomm_route #(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned NUM_NBR   = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned SEL_W     = 2
) (
  input  logic [NUM_PORTS*SEL_W-1:0]  port_sel,
  input  logic [NUM_PORTS*DATA_W-1:0] port_wr_data,
  input  logic [NUM_PORTS-1:0]        rd_wants,
  input  logic [NUM_PORTS-1:0]        wr_wants,
  input  logic [NUM_PORTS-1:0]        rd_fire,
  input  logic [NUM_PORTS-1:0]        wr_fire,
  output logic [NUM_PORTS-1:0]        rd_shadow,
  output logic [NUM_PORTS-1:0]        wr_shadow,
  output logic [NUM_NBR-1:0]          link_wr_en,
  output logic [NUM_NBR*DATA_W-1:0]   link_wr_data,
  output logic [NUM_NBR-1:0]          link_rd_take
);
  // Lower port index wins; shadowing depends only on wants, so no chain.
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      rd_shadow[p] = 1'b0;
      wr_shadow[p] = 1'b0;
      for (int q = 0; q < p; q++) begin
        if (port_sel[q*SEL_W +: SEL_W] == port_sel[p*SEL_W +: SEL_W]) begin
          if (rd_wants[q]) rd_shadow[p] = 1'b1;
          if (wr_wants[q]) wr_shadow[p] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    link_wr_en   = '0;
    link_wr_data = '0;
    link_rd_take = '0;
    for (int n = 0; n < NUM_NBR; n++) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (port_sel[p*SEL_W +: SEL_W] == SEL_W'(n)) begin
          if (wr_fire[p]) begin
            link_wr_en[n]                   = 1'b1;
            link_wr_data[n*DATA_W +: DATA_W] = port_wr_data[p*DATA_W +: DATA_W];
          end
          if (rd_fire[p]) link_rd_take[n] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nbcomm_port.sv
module nbcomm_port #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              rd_avail,
  input  logic              wr_avail,
  input  logic              stall,
  input  logic [DATA_W-1:0] rd_word,
  output logic              rd_wants,
  output logic              wr_wants,
  output logic              rd_fire,
  output logic              wr_fire,
  output logic              blocked,
  output logic [DATA_W-1:0] rd_data
);
  logic              done_rd, done_wr;
  logic [DATA_W-1:0] held_word;

  assign rd_wants = rd_req && !done_rd;
  assign wr_wants = wr_req && !done_wr;
  assign rd_fire  = rd_wants && rd_avail;
  assign wr_fire  = wr_wants && wr_avail;
  assign blocked  = (rd_wants && !rd_avail) || (wr_wants && !wr_avail);
  assign rd_data  = rd_fire ? rd_word : held_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_rd   <= 1'b0;
      done_wr   <= 1'b0;
      held_word <= '0;
    end else begin
      if (stall) begin
        done_rd <= done_rd | rd_fire;
        done_wr <= done_wr | wr_fire;
      end else begin
        done_rd <= 1'b0;
        done_wr <= 1'b0;
      end
      if (rd_fire) held_word <= rd_word;
    end
  end

  // R5/R3: a blocked port always reaches the shared stall
  a_r5_blocked_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> stall);
  // R9: a finished read keeps its word while the engine is still stalled
  a_r9_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && stall) |=> (rd_data == $past(rd_word)) || !stall);
endmodule

// File: rtl/nbcomm_unit.sv
module nbcomm_unit
  import nbcomm_pkg::*;
#(
  parameter int unsigned NUM_PORTS = PORTS_DEF,
  parameter int unsigned NUM_NBR   = NBRS_DEF,
  parameter int unsigned DATA_W    = WORD_W_DEF,
  localparam int unsigned SEL_W    = sel_width(NUM_NBR)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*SEL_W-1:0]  port_sel,
  input  logic [NUM_PORTS-1:0]        port_rd_req,
  input  logic [NUM_PORTS-1:0]        port_wr_req,
  input  logic [NUM_PORTS*DATA_W-1:0] port_wr_data,
  output logic [NUM_PORTS*DATA_W-1:0] port_rd_data,
  output logic                        stall,
  output logic [NUM_NBR-1:0]          tx_valid,
  input  logic [NUM_NBR-1:0]          tx_ready,
  output logic [NUM_NBR*DATA_W-1:0]   tx_data,
  input  logic [NUM_NBR-1:0]          rx_valid,
  output logic [NUM_NBR-1:0]          rx_ready,
  input  logic [NUM_NBR*DATA_W-1:0]   rx_data
);
  logic [NUM_PORTS-1:0]      rd_wants, wr_wants, rd_fire, wr_fire;
  logic [NUM_PORTS-1:0]      rd_shadow, wr_shadow, rd_avail, wr_avail, blocked;
  logic [NUM_NBR-1:0]        link_full, link_wr_en;
  logic [NUM_NBR*DATA_W-1:0] link_word, link_wr_data;

  assign tx_valid = link_full;
  assign tx_data  = link_word;
  assign stall    = |blocked;

  nbcomm_route #(
    .NUM_PORTS(NUM_PORTS), .NUM_NBR(NUM_NBR), .DATA_W(DATA_W), .SEL_W(SEL_W)
  ) u_route (
    .port_sel     (port_sel),
    .port_wr_data (port_wr_data),
    .rd_wants     (rd_wants),
    .wr_wants     (wr_wants),
    .rd_fire      (rd_fire),
    .wr_fire      (wr_fire),
    .rd_shadow    (rd_shadow),
    .wr_shadow    (wr_shadow),
    .link_wr_en   (link_wr_en),
    .link_wr_data (link_wr_data),
    .link_rd_take (rx_ready)
  );

  for (genvar n = 0; n < NUM_NBR; n++) begin : g_link
    nbcomm_mailbox #(.DATA_W(DATA_W)) u_box (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (link_wr_en[n]),
      .wr_word (link_wr_data[n*DATA_W +: DATA_W]),
      .take    (tx_ready[n]),
      .full    (link_full[n]),
      .word    (link_word[n*DATA_W +: DATA_W])
    );

    logic [NUM_PORTS-1:0] writers;
    always_comb begin
      for (int p = 0; p < NUM_PORTS; p++)
        writers[p] = wr_fire[p] && (port_sel[p*SEL_W +: SEL_W] == SEL_W'(n));
    end

    // R6: at most one port loads a given link per cycle
    a_r6_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(writers));
    // R12: no word is taken from an empty incoming link
    a_r12_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready[n] |-> rx_valid[n]);
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] word_in;
    assign sel         = port_sel[p*SEL_W +: SEL_W];
    assign word_in     = rx_data[32'(sel)*DATA_W +: DATA_W];
    assign rd_avail[p] = rx_valid[sel] && !rd_shadow[p];
    assign wr_avail[p] = !link_full[sel] && !wr_shadow[p];

    nbcomm_port #(.DATA_W(DATA_W)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_req   (port_rd_req[p]),
      .wr_req   (port_wr_req[p]),
      .rd_avail (rd_avail[p]),
      .wr_avail (wr_avail[p]),
      .stall    (stall),
      .rd_word  (word_in),
      .rd_wants (rd_wants[p]),
      .wr_wants (wr_wants[p]),
      .rd_fire  (rd_fire[p]),
      .wr_fire  (wr_fire[p]),
      .blocked  (blocked[p]),
      .rd_data  (port_rd_data[p*DATA_W +: DATA_W])
    );

    // R5: a pending read of an empty link holds the engine
    a_r5_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_wants[p] && !rx_valid[sel]) |-> stall);
  end

  // R1: nothing requested means nothing stalls
  a_r1_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ((port_rd_req == '0) && (port_wr_req == '0)) |-> !stall);
endmodule

// File: tb/nbcomm_unit_test.sv
module nbcomm_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  port_sel = '0;
  logic [1:0]  port_rd_req = '0, port_wr_req = '0;
  logic [31:0] port_wr_data = '0;
  logic [31:0] port_rd_data;
  logic        stall;
  logic [3:0]  tx_valid, rx_ready;
  logic [3:0]  tx_ready = '0, rx_valid = '0;
  logic [63:0] tx_data, rx_data;

  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  nbcomm_unit uut (
    .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .port_rd_req(port_rd_req),
    .port_wr_req(port_wr_req), .port_wr_data(port_wr_data),
    .port_rd_data(port_rd_data), .stall(stall), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data)
  );

  function automatic logic [15:0] pat(input int n);
    return 16'hC000 + 16'(n) * 16'h0111;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Row: rd0, sel0, rd1, sel1, rx_valid, exp stall, exp rx_ready, spare
  localparam int ROWS = 8;
  localparam logic [15:0] VEC [ROWS] = '{
    {1'b1, 2'd0, 1'b0, 2'd0, 4'b0001, 1'b0, 4'b0001, 1'b0},  // R4
    {1'b1, 2'd2, 1'b0, 2'd0, 4'b0000, 1'b1, 4'b0000, 1'b0},  // R5
    {1'b1, 2'd1, 1'b1, 2'd3, 4'b1010, 1'b0, 4'b1010, 1'b0},  // R8
    {1'b1, 2'd1, 1'b1, 2'd1, 4'b0010, 1'b1, 4'b0010, 1'b0},  // R7
    {1'b0, 2'd0, 1'b1, 2'd3, 4'b1000, 1'b0, 4'b1000, 1'b0},  // R11
    {1'b1, 2'd0, 1'b1, 2'd2, 4'b0001, 1'b1, 4'b0001, 1'b0},  // R9
    {1'b0, 2'd0, 1'b0, 2'd0, 4'b1111, 1'b0, 4'b0000, 1'b0},  // R12
    {1'b0, 2'd0, 1'b1, 2'd0, 4'b0000, 1'b1, 4'b0000, 1'b0}   // R5
  };

  initial begin
    for (int n = 0; n < 4; n++) rx_data[n*16 +: 16] = pat(n);
    step(); step();
    #5;
    check(tx_valid == 4'b0 && stall == 1'b0, "R1 reset", {tx_valid, 3'b0, stall}, 0);
    step();
    rst_n = 1'b1;
    #5;
    check(tx_valid == 4'b0 && stall == 1'b0, "R1 idle", {tx_valid, 3'b0, stall}, 0);

    // Vector table: read paths
    for (int i = 0; i < ROWS; i++) begin
      logic [15:0] v;
      v = VEC[i];
      step();
      port_rd_req = {v[12], v[15]};
      port_sel    = {v[11:10], v[14:13]};
      rx_valid    = v[9:6];
      #5;
      check(stall == v[5], $sformatf("R4/R5/R7/R8 row %0d stall", i), stall, v[5]);
      check(rx_ready == v[4:1], $sformatf("R12 row %0d rx_ready", i), rx_ready, v[4:1]);
      if (v[15] && v[9:6][v[14:13]])
        check(port_rd_data[15:0] == pat(v[14:13]), $sformatf("R4/R11 row %0d data0", i),
              port_rd_data[15:0], pat(v[14:13]));
      if (v[12] && v[9:6][v[11:10]] && !(v[15] && v[14:13] == v[11:10]))
        check(port_rd_data[31:16] == pat(v[11:10]), $sformatf("R11 row %0d data1", i),
              port_rd_data[31:16], pat(v[11:10]));
      step();
      port_rd_req = '0;
      rx_valid    = '0;
    end

    // R2: write to empty link 1
    step();
    port_sel = 4'b0001; port_wr_req = 2'b01; port_wr_data[15:0] = 16'h1234;
    #5 check(stall == 1'b0, "R2 no stall", stall, 0);
    step();
    port_wr_req = '0;
    #5 check(tx_valid == 4'b0010 && tx_data[31:16] == 16'h1234, "R2/R11 link1 loaded",
             {tx_valid, tx_data[31:16]}, {4'b0010, 16'h1234});
    // R10: hold while not accepted
    step(); step();
    #5 check(tx_valid[1] && tx_data[31:16] == 16'h1234, "R10 held", tx_data[31:16], 16'h1234);

    // R3: write into a full link
    step();
    port_wr_req = 2'b01; port_wr_data[15:0] = 16'h5678;
    #5 check(stall == 1'b1, "R3 stall on full", stall, 1);
    step();
    #5 check(stall && tx_data[31:16] == 16'h1234, "R3 old word kept", tx_data[31:16], 16'h1234);
    tx_ready[1] = 1'b1;
    step();
    tx_ready[1] = 1'b0;
    #5 check(stall == 1'b0, "R3 completes after drain", stall, 0);
    step();
    port_wr_req = '0;
    #5 check(tx_valid[1] && tx_data[31:16] == 16'h5678, "R3 new word", tx_data[31:16], 16'h5678);
    tx_ready[1] = 1'b1;
    step();
    tx_ready[1] = 1'b0;
    #5 check(tx_valid == 4'b0, "R3 link drained", tx_valid, 0);

    // R6/R9: both ports write link 2
    step();
    port_sel = 4'b1010; port_wr_req = 2'b11; port_wr_data = {16'hBBBB, 16'hAAAA};
    #5 check(stall == 1'b1, "R6 port1 stalls", stall, 1);
    step();
    #5 check(stall && tx_data[47:32] == 16'hAAAA, "R6 port0 first", tx_data[47:32], 16'hAAAA);
    tx_ready[2] = 1'b1;
    step();
    tx_ready[2] = 1'b0;
    #5 check(stall == 1'b0, "R9 port0 not repeated", stall, 0);
    step();
    port_wr_req = '0;
    #5 check(tx_valid[2] && tx_data[47:32] == 16'hBBBB, "R6 port1 second", tx_data[47:32], 16'hBBBB);
    tx_ready[2] = 1'b1;
    step();
    tx_ready[2] = 1'b0;
    #5 check(tx_valid == 4'b0, "R9 single word each", tx_valid, 0);

    // R9: read held while other port stalls
    step();
    port_sel = 4'b1100; port_rd_req = 2'b11; rx_valid = 4'b0001;
    #5 check(stall && rx_ready == 4'b0001, "R9 split outcome", {stall, rx_ready}, 5'b10001);
    step();
    rx_valid = 4'b0000; rx_data[15:0] = 16'hDEAD;
    #5 check(stall && port_rd_data[15:0] == pat(0), "R9 word held",
             port_rd_data[15:0], pat(0));
    step();
    rx_valid = 4'b1000;
    #5 check(!stall && port_rd_data == {pat(3), pat(0)} && rx_ready == 4'b1000,
             "R5/R9 both done", port_rd_data, {pat(3), pat(0)});
    step();
    port_rd_req = '0; rx_valid = '0;
    #5 check(stall == 1'b0, "R1 quiet after", stall, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule